// File: doc/BRIEF.md
# PHY Reset and Power-Mode Controller

This block sequences reset and power state for a simple Ethernet PHY management model. Three things can reset it. An asynchronous power-on reset starts a timed reset sequence by itself, so the block needs no external reset after power-up. An active-low hardware reset pin counts only when it stays low for a full reset interval; shorter glitches are filtered out. A software reset starts when bit 15 of the basic control register (address 0x00) is written as 1. While any reset sequence runs, the control register is held at its default value and the strap configuration inputs are captured into flops. When the sequence ends, the straps are frozen.

The rest of the control register holds mode bits. Bit 11 puts the device into power-down. When energy detect is enabled and the single line-activity input shows an idle cable, the block enters a low-power state. In that state it raises a one-cycle transmit pulse at a fixed interval. Activity on the line takes it back to normal power at once.

Top module: `phy_rstpwr_ctrl`

## Requirements
- R1: After the power-on reset input `por_n` is released, `reset_active` stays 1 for exactly RST_CYC clock cycles (CLK_HZ/1e6, one microsecond; 50 by default) and then falls to 0.
- R2: A low pulse on `hw_rst_n` that leaves the synchronised pin low for fewer than RST_CYC consecutive cycles has no effect: `reset_active` stays 0 and the register value is unchanged.
- R3: Once the synchronised `hw_rst_n` has been low for RST_CYC consecutive cycles, `reset_active` rises on the next cycle. It stays 1 while the pin is held low, and falls RST_CYC cycles after the low qualification ends. The pin passes through two synchroniser flops first.
- R4: `strap_q` follows `strap_in` on every clock edge while `reset_active` is 1. It holds its value on every edge while `reset_active` is 0.
- R5: A write to address 0 with data bit 15 set, made while no reset is running, starts a reset of RST_CYC cycles from the next cycle. Bit 15 of `bmcr_q` reads 1 while any reset runs and 0 otherwise.
- R6: While `reset_active` is 1, and for one cycle after a software-reset write, `bmcr_q[14:0]` holds BMCR_DEF[14:0] (default 0x3100). Writes made during that time are ignored, and writes to any address other than 0 never change `bmcr_q`.
- R7: A write to address 0 updates `bmcr_q[14:0]` on the next cycle. `power_down` is 1 exactly when `bmcr_q` bit 11 is 1 and no reset is running.
- R8: `low_power` is a register. In the cycle after an edge where `ed_enable` is 1, `line_active` is 0, no reset is running and bit 11 is 0, it reads 1. Otherwise it reads 0, so line activity clears it one cycle later.
- R9: While `low_power` stays 1, `tx_pulse` is 1 for a single cycle on the ED_PERIOD-th cycle of low power and every ED_PERIOD cycles after that (32 by default). It is never 1 outside low power.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Internal power-on reset, asynchronous, active low |
| hw_rst_n | input | 1 | Hardware reset pin, asynchronous, active low, filtered |
| strap_in | input | STRAP_W | Strap configuration inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register write address |
| reg_wdata | input | 16 | Register write data |
| ed_enable | input | 1 | Energy-detect enable |
| line_active | input | 1 | Line-activity indication |
| reset_active | output | 1 | Internal synchronous reset in progress |
| bmcr_q | output | 16 | Basic control register readback, bit 15 = reset busy |
| strap_q | output | STRAP_W | Latched strap configuration |
| power_down | output | 1 | Power-down mode active |
| low_power | output | 1 | Energy-detect low-power state |
| tx_pulse | output | 1 | One-cycle detect-pulse request to the transmitter |

## Verification
The bench applies hardware reset pulses just shorter and well longer than one microsecond. A filter that used the raw pin or counted from the wrong edge would either reset on the glitch or start late, and the reference model would catch the cycle offset. Software-reset writes are followed by further writes during the busy window, which exposes a design that lets mode bits leak through or that clears bit 15 early. The bench also changes the straps outside reset, then leaves the line idle long enough to count several detect pulses before activity and power-down break the low-power state. These steps catch strap flops that stay open, pulse periods that are off by one, and low power that survives a power-down.

// File: rtl/phy_rpc_pkg.sv
package phy_rpc_pkg;
  localparam int unsigned REG_AW      = 5;
  localparam int unsigned REG_DW      = 16;
  localparam int unsigned CTRL_ADDR   = 0;
  localparam int unsigned BIT_SWRST   = 15;
  localparam int unsigned BIT_PWRDN   = 11;
endpackage

// File: rtl/rpc_hwrst_filter.sv
module rpc_hwrst_filter #(
  parameter int unsigned MIN_LOW = 50
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_n,
  output logic qual
);
  localparam int unsigned CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LIM = CW'(MIN_LOW);

  logic          sync1_q, sync2_q;
  logic [CW-1:0] lo_q, lo_d;

  always_comb begin
    lo_d = '0;
    if (!sync2_q) lo_d = (lo_q == LIM) ? LIM : lo_q + CW'(1);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      lo_q    <= '0;
    end else begin
      sync1_q <= pin_n;
      sync2_q <= sync1_q;
      lo_q    <= lo_d;
    end
  end

  assign qual = (lo_q == LIM);

  // R2: qualification only follows a low synchronised sample
  p_qual_after_low_r2: assert property (@(posedge clk) disable iff (!por_n)
    qual |-> $past(!sync2_q));
endmodule

// File: rtl/rpc_reset_seq.sv
module rpc_reset_seq #(
  parameter int unsigned RST_CYC = 50
) (
  input  logic clk,
  input  logic por_n,
  input  logic hw_qual,
  input  logic sw_req,
  output logic sw_start,
  output logic active
);
  localparam int unsigned CW = $clog2(RST_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(RST_CYC);

  logic [CW-1:0] tmr_q, tmr_d;

  assign active   = (tmr_q != '0);
  assign sw_start = sw_req && !active;

  always_comb begin
    tmr_d = tmr_q;
    if (hw_qual || sw_start) tmr_d = LOAD;
    else if (active)         tmr_d = tmr_q - CW'(1);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) tmr_q <= LOAD;
    else        tmr_q <= tmr_d;
  end

  p_hw_trigger_r3: assert property (@(posedge clk) disable iff (!por_n)
    hw_qual |=> active);
  p_sw_trigger_r5: assert property (@(posedge clk) disable iff (!por_n)
    sw_start |=> (active && tmr_q == LOAD));
  p_release_r1: assert property (@(posedge clk) disable iff (!por_n)
    $fell(active) |-> ($past(tmr_q) == CW'(1)));
endmodule

// File: rtl/rpc_ed_ctrl.sv
module rpc_ed_ctrl #(
  parameter int unsigned ED_PERIOD = 32
) (
  input  logic clk,
  input  logic por_n,
  input  logic ed_enable,
  input  logic line_active,
  input  logic in_reset,
  input  logic pd_bit,
  output logic low_power,
  output logic tx_pulse
);
  localparam int unsigned PW = (ED_PERIOD > 2) ? $clog2(ED_PERIOD) : 1;
  localparam logic [PW-1:0] LAST = PW'(ED_PERIOD - 1);

  logic          lp_q, lp_d;
  logic [PW-1:0] pc_q, pc_d;

  always_comb begin
    lp_d = ed_enable && !line_active && !in_reset && !pd_bit;
    pc_d = '0;
    if (lp_q && pc_q != LAST) pc_d = pc_q + PW'(1);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lp_q <= 1'b0;
      pc_q <= '0;
    end else begin
      lp_q <= lp_d;
      pc_q <= pc_d;
    end
  end

  assign low_power = lp_q;
  assign tx_pulse  = lp_q && (pc_q == LAST);

  p_pulse_in_lp_r9: assert property (@(posedge clk) disable iff (!por_n)
    tx_pulse |-> low_power);
  p_lp_exit_r8: assert property (@(posedge clk) disable iff (!por_n)
    line_active |=> !low_power);
endmodule

// File: rtl/phy_rstpwr_ctrl.sv
module phy_rstpwr_ctrl
  import phy_rpc_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned ED_PERIOD = 32,
  parameter int unsigned STRAP_W   = 4,
  parameter logic [15:0] BMCR_DEF  = 16'h3100
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               hw_rst_n,
  input  logic [STRAP_W-1:0] strap_in,
  input  logic               reg_wr,
  input  logic [4:0]         reg_addr,
  input  logic [15:0]        reg_wdata,
  input  logic               ed_enable,
  input  logic               line_active,
  output logic               reset_active,
  output logic [15:0]        bmcr_q,
  output logic [STRAP_W-1:0] strap_q,
  output logic               power_down,
  output logic               low_power,
  output logic               tx_pulse
);
  localparam int unsigned RST_CYC = CLK_HZ / 1_000_000;

  logic              hw_qual, sw_req, sw_start, ctrl_wr;
  logic [14:0]       mode_q, mode_d;
  logic [STRAP_W-1:0] strap_r;

  assign ctrl_wr = reg_wr && (reg_addr == REG_AW'(CTRL_ADDR));
  assign sw_req  = ctrl_wr && reg_wdata[BIT_SWRST];

  rpc_hwrst_filter #(.MIN_LOW(RST_CYC)) u_filt (
    .clk(clk), .por_n(por_n), .pin_n(hw_rst_n), .qual(hw_qual));

  rpc_reset_seq #(.RST_CYC(RST_CYC)) u_seq (
    .clk(clk), .por_n(por_n), .hw_qual(hw_qual), .sw_req(sw_req),
    .sw_start(sw_start), .active(reset_active));

  always_comb begin
    mode_d = mode_q;
    if (reset_active || sw_start) mode_d = BMCR_DEF[14:0];
    else if (ctrl_wr)             mode_d = reg_wdata[14:0];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) mode_q <= BMCR_DEF[14:0];
    else        mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)            strap_r <= '0;
    else if (reset_active) strap_r <= strap_in;
  end

  assign strap_q    = strap_r;
  assign bmcr_q     = {reset_active, mode_q};
  assign power_down = mode_q[BIT_PWRDN] && !reset_active;

  rpc_ed_ctrl #(.ED_PERIOD(ED_PERIOD)) u_ed (
    .clk(clk), .por_n(por_n), .ed_enable(ed_enable), .line_active(line_active),
    .in_reset(reset_active), .pd_bit(mode_q[BIT_PWRDN]),
    .low_power(low_power), .tx_pulse(tx_pulse));

  p_pd_not_in_reset_r7: assert property (@(posedge clk) disable iff (!por_n)
    power_down |-> !reset_active);
  p_strap_frozen_r4: assert property (@(posedge clk) disable iff (!por_n)
    $past(!reset_active) |-> $stable(strap_q));
  p_mode_default_r6: assert property (@(posedge clk) disable iff (!por_n)
    $past(reset_active) |-> (bmcr_q[14:0] == BMCR_DEF[14:0]));
endmodule

// File: tb/phy_rstpwr_ctrl_bench.sv
module phy_rstpwr_ctrl_bench;
  localparam int RC  = 50;
  localparam int P   = 32;
  localparam logic [14:0] DEF = 15'h3100;

  logic       clk = 1'b0;
  logic       por_n, hw_rst_n, reg_wr, ed_enable, line_active;
  logic [3:0] strap_in;
  logic [4:0] reg_addr;
  logic [15:0] reg_wdata;
  logic        reset_active, power_down, low_power, tx_pulse;
  logic [15:0] bmcr_q;
  logic [3:0]  strap_q;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  phy_rstpwr_ctrl u_phy_rstpwr_ctrl (
    .clk(clk), .por_n(por_n), .hw_rst_n(hw_rst_n), .strap_in(strap_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ed_enable(ed_enable), .line_active(line_active),
    .reset_active(reset_active), .bmcr_q(bmcr_q), .strap_q(strap_q),
    .power_down(power_down), .low_power(low_power), .tx_pulse(tx_pulse));

  // behavioural reference model
  int   m_tmr, m_lo, m_pc;
  bit   m_s1, m_s2, m_lp;
  logic [14:0] m_bm;
  logic [3:0]  m_strap;
  int   n_pulses;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_tmr = RC; m_lo = 0; m_pc = 0; m_s1 = 1; m_s2 = 1; m_lp = 0;
      m_bm = DEF; m_strap = '0;
    end else begin
      bit qual, sw, ra, cw;
      int n_tmr, n_lo, n_pc;
      logic [14:0] n_bm;
      qual = (m_lo == RC);
      ra   = (m_tmr != 0);
      cw   = reg_wr && reg_addr == 5'd0;
      sw   = cw && reg_wdata[15] && !ra;
      n_tmr = (qual || sw) ? RC : (ra ? m_tmr - 1 : 0);
      n_bm  = (ra || sw) ? DEF : (cw ? reg_wdata[14:0] : m_bm);
      n_lo  = !m_s2 ? ((m_lo == RC) ? RC : m_lo + 1) : 0;
      n_pc  = (m_lp && m_pc != P - 1) ? m_pc + 1 : 0;
      if (ra) m_strap = strap_in;
      m_lp  = ed_enable && !line_active && !ra && !m_bm[11];
      m_s2  = m_s1; m_s1 = hw_rst_n;
      m_tmr = n_tmr; m_bm = n_bm; m_lo = n_lo; m_pc = n_pc;
    end
  end

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (por_n && !done) begin
      bit ra;
      ra = (m_tmr != 0);
      chk("R3", "reset_active", {15'd0, reset_active}, {15'd0, ra});
      chk("R5", "bmcr_q", bmcr_q, {ra, m_bm});
      chk("R4", "strap_q", {12'd0, strap_q}, {12'd0, m_strap});
      chk("R7", "power_down", {15'd0, power_down}, {15'd0, m_bm[11] && !ra});
      chk("R8", "low_power", {15'd0, low_power}, {15'd0, m_lp});
      chk("R9", "tx_pulse", {15'd0, tx_pulse}, {15'd0, m_lp && m_pc == P - 1});
      if (tx_pulse) n_pulses++;
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  initial begin
    int cnt;
    por_n = 0; hw_rst_n = 1; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    ed_enable = 0; line_active = 1; strap_in = 4'hA;
    cyc(3);
    @(negedge clk); por_n = 1;
    @(negedge clk);
    chk("R1", "reset_active after POR", {15'd0, reset_active}, 16'd1);
    cnt = 1;
    while (reset_active && cnt < 200) begin @(negedge clk); cnt++; end
    chk("R1", "POR reset length", 16'(cnt), 16'(RC));
    chk("R1", "straps after POR", {12'd0, strap_q}, 16'h000A);
    strap_in = 4'h5; cyc(5);
    chk("R4", "straps frozen", {12'd0, strap_q}, 16'h000A);

    wr(5'd0, 16'h0800); cyc(1);
    chk("R7", "power_down set", {15'd0, power_down}, 16'd1);
    wr(5'd1, 16'h0000); cyc(1);
    chk("R6", "other address ignored", bmcr_q, 16'h0800);
    wr(5'd0, 16'h0000); cyc(1);
    chk("R7", "power_down clear", {15'd0, power_down}, 16'd0);

    // short hardware pulse
    hw_rst_n = 0; cyc(RC - 2); hw_rst_n = 1;
    cnt = 0;
    for (int i = 0; i < RC; i++) begin @(negedge clk); if (reset_active) cnt++; end
    chk("R2", "short pulse ignored", 16'(cnt), 16'd0);
    chk("R2", "strap unchanged", {12'd0, strap_q}, 16'h000A);

    // long hardware pulse
    wr(5'd0, 16'h0800);
    hw_rst_n = 0; cyc(RC + 30);
    chk("R3", "long pulse reset", {15'd0, reset_active}, 16'd1);
    hw_rst_n = 1; cyc(RC + 5);
    chk("R3", "reset released", {15'd0, reset_active}, 16'd0);
    chk("R4", "straps relatched", {12'd0, strap_q}, 16'h0005);
    chk("R6", "default after hw reset", bmcr_q, {1'b0, DEF});

    // software reset with writes while busy
    strap_in = 4'hC;
    wr(5'd0, 16'h8800);
    chk("R5", "bit15 busy", {15'd0, bmcr_q[15]}, 16'd1);
    wr(5'd0, 16'h0800);
    chk("R6", "write during reset", bmcr_q, {1'b1, DEF});
    cyc(RC);
    chk("R5", "bit15 self-clear", {15'd0, bmcr_q[15]}, 16'd0);
    chk("R6", "mode bits default", bmcr_q, {1'b0, DEF});
    chk("R4", "straps after sw reset", {12'd0, strap_q}, 16'h000C);

    // energy detect
    ed_enable = 1; line_active = 0; n_pulses = 0;
    cyc(4 * P + 3);
    chk("R8", "in low power", {15'd0, low_power}, 16'd1);
    chk("R9", "pulse count", 16'(n_pulses), 16'd4);
    line_active = 1; cyc(2);
    chk("R8", "activity wakes", {15'd0, low_power}, 16'd0);
    line_active = 0; cyc(3);
    wr(5'd0, 16'h0800); cyc(1);
    chk("R8", "power down blocks low power", {15'd0, low_power}, 16'd0);
    cyc(5);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule